// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block chooses, for each of the two ALU operands of a five-stage in-order integer pipeline, whether the operand comes from the register file or is bypassed from a result that has not yet been written back. Such a result can sit in the stage directly after execute (the "near" producer) or in the stage after that (the "far" producer). Registers are read in decode and written in the last stage, so only read-after-write dependences reach this block. A consumer three instructions behind its producer reads the register file directly, because the file is written in the first half of a cycle and read in the second half.

The select outputs are registered. The block compares the source register numbers of the instruction now in decode against the destinations of the two instructions that will sit in the near and far slots when that instruction executes. Those are the instruction now in execute and the instruction now in the near slot. The selects then drive the two operand multiplexers directly, from a flop, during execute. The near producer takes precedence over the far one. Register zero is never bypassed. A producer whose write flag is clear is never bypassed.

Top module: `fwdu_bypass_sel`

## Requirements
- R1: When neither producer qualifies for an operand, that operand's select is 2'b00 (register file).
- R2: When the near producer has its write flag set, a nonzero destination, and a destination equal to the operand's source, the select is 2'b10.
- R3: When only the far producer qualifies (write flag set, nonzero destination equal to the source), the select is 2'b01.
- R4: When both producers qualify for the same operand, the select is 2'b10 (the near, younger result wins).
- R5: A source or destination number of zero never produces a bypass, even with the write flag set; the select stays 2'b00 unless the other producer qualifies.
- R6: A producer whose write flag is clear is ignored. If the other producer qualifies, its code is selected; otherwise 2'b00.
- R7: Operand A uses `dec_src_a` and drives `sel_a`; operand B uses `dec_src_b` and drives `sel_b`. Each is decided independently of the other.
- R8: A select output never takes the value 2'b11.
- R9: A select reflects the inputs sampled at the previous rising clock edge and does not change between edges.
- R10: A rising edge with `rst` high sets both selects to 2'b00, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a | input | AW (5) | First source register number of the decoding instruction |
| dec_src_b | input | AW (5) | Second source register number of the decoding instruction |
| near_dst | input | AW (5) | Destination of the instruction that will occupy the slot after execute |
| near_wr | input | 1 | Register-write flag of that instruction |
| far_dst | input | AW (5) | Destination of the instruction that will occupy the slot before write-back completes |
| far_wr | input | 1 | Register-write flag of that instruction |
| sel_a | output | 2 | Operand A select: 00 register file, 10 near, 01 far |
| sel_b | output | 2 | Operand B select, same encoding |

## Verification
A wrong comparison or priority inside the block appears one edge later as a wrong select code on `sel_a` or `sel_b`. The effect is a stale operand (code 00 where a bypass was due), the older of two results (01 instead of 10), or a bypass of register zero or of a non-writing instruction. Each scenario applies one input pattern, so a mismatch can be traced to the edge that captured it. Swapping the two operands' wiring or their code bits shows up as soon as the two operands are given different dependences.

// File: rtl/fwdu_pkg.sv
package fwdu_pkg;

  // Operand source code, shared by the selector and its users.
  typedef enum logic [1:0] {
    BYP_REGFILE = 2'b00,
    BYP_FAR     = 2'b01,
    BYP_NEAR    = 2'b10
  } byp_sel_e;

endpackage

// File: rtl/fwdu_stage_hit.sv
// One producer against one consumer source: qualifies when the producer
// writes a nonzero register that equals the source.
module fwdu_stage_hit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wr,
  output logic          hit
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit = wr && (dst != ZERO_REG) && (dst == src);
  end

endmodule

// File: rtl/fwdu_operand_pick.sv
// Priority pick for one operand: the near (younger) producer beats the far one.
module fwdu_operand_pick
  import fwdu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] near_dst,
  input  logic          near_wr,
  input  logic [AW-1:0] far_dst,
  input  logic          far_wr,
  output byp_sel_e      sel
);

  logic near_hit;
  logic far_hit;

  fwdu_stage_hit #(.AW(AW)) near_cmp_i (
    .src (src),
    .dst (near_dst),
    .wr  (near_wr),
    .hit (near_hit)
  );

  fwdu_stage_hit #(.AW(AW)) far_cmp_i (
    .src (src),
    .dst (far_dst),
    .wr  (far_wr),
    .hit (far_hit)
  );

  always_comb begin
    if (near_hit)     sel = BYP_NEAR;
    else if (far_hit) sel = BYP_FAR;
    else              sel = BYP_REGFILE;
  end

endmodule

// File: rtl/fwdu_bypass_sel.sv
// Registered bypass selector for both ALU operands.
module fwdu_bypass_sel
  import fwdu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic [AW-1:0] near_dst,
  input  logic          near_wr,
  input  logic [AW-1:0] far_dst,
  input  logic          far_wr,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b
);

  localparam int NUM_OPS = 2;

  logic [AW-1:0] op_src  [NUM_OPS];
  byp_sel_e      op_next [NUM_OPS];
  byp_sel_e      op_q    [NUM_OPS];

  assign op_src[0] = dec_src_a;
  assign op_src[1] = dec_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwdu_operand_pick #(.AW(AW)) pick_i (
      .src      (op_src[g]),
      .near_dst (near_dst),
      .near_wr  (near_wr),
      .far_dst  (far_dst),
      .far_wr   (far_wr),
      .sel      (op_next[g])
    );

    always_ff @(posedge clk) begin
      if (rst) op_q[g] <= BYP_REGFILE;
      else     op_q[g] <= op_next[g];
    end
  end

  assign sel_a = op_q[0];
  assign sel_b = op_q[1];

endmodule

// File: rtl/fwdu_bypass_sel_chk.sv
// Port-level checker, bound to every instance of the selector.
module fwdu_bypass_sel_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] dec_src_a,
  input logic [AW-1:0] dec_src_b,
  input logic [AW-1:0] near_dst,
  input logic          near_wr,
  input logic [AW-1:0] far_dst,
  input logic          far_wr,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  logic nq_a, fq_a, nq_b, fq_b;
  assign nq_a = near_wr && (near_dst != '0) && (near_dst == dec_src_a);
  assign fq_a = far_wr  && (far_dst  != '0) && (far_dst  == dec_src_a);
  assign nq_b = near_wr && (near_dst != '0) && (near_dst == dec_src_b);
  assign fq_b = far_wr  && (far_dst  != '0) && (far_dst  == dec_src_b);

  // R2 / R4: near producer wins
  a_r2_near_a: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(nq_a) |-> sel_a == 2'b10);
  a_r2_near_b: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(nq_b) |-> sel_b == 2'b10);

  // R3: far producer alone
  a_r3_far_a: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(fq_a && !nq_a) |-> sel_a == 2'b01);
  a_r3_far_b: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(fq_b && !nq_b) |-> sel_b == 2'b01);

  // R1 / R6: no qualifying producer
  a_r1_none_a: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!fq_a && !nq_a) |-> sel_a == 2'b00);
  a_r1_none_b: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!fq_b && !nq_b) |-> sel_b == 2'b00);

  // R5: register zero never bypassed
  a_r5_zero_a: assert property (@(posedge clk) disable iff (rst)
    past_ok && sel_a != 2'b00 |-> $past(dec_src_a) != '0);
  a_r5_zero_b: assert property (@(posedge clk) disable iff (rst)
    past_ok && sel_b != 2'b00 |-> $past(dec_src_b) != '0);

  // R8: illegal code never seen
  a_r8_legal: assert property (@(posedge clk) disable iff (rst)
    sel_a != 2'b11 && sel_b != 2'b11);

  // R10: reset clears both selects
  a_r10_reset: assert property (@(posedge clk)
    $past(rst) |-> sel_a == 2'b00 && sel_b == 2'b00);

endmodule

bind fwdu_bypass_sel fwdu_bypass_sel_chk #(.AW(AW)) chk_i (.*);

// File: tb/fwdu_bypass_sel_tb.sv
module fwdu_bypass_sel_tb_top;

  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] dec_src_a = '0;
  logic [AW-1:0] dec_src_b = '0;
  logic [AW-1:0] near_dst  = '0;
  logic          near_wr   = 1'b0;
  logic [AW-1:0] far_dst   = '0;
  logic          far_wr    = 1'b0;
  logic [1:0]    sel_a;
  logic [1:0]    sel_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  fwdu_bypass_sel #(.AW(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .dec_src_a (dec_src_a),
    .dec_src_b (dec_src_b),
    .near_dst  (near_dst),
    .near_wr   (near_wr),
    .far_dst   (far_dst),
    .far_wr    (far_wr),
    .sel_a     (sel_a),
    .sel_b     (sel_b)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive one pattern at a falling edge, then sample after the next rising edge.
  task automatic apply(input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                       input logic [AW-1:0] nd, input logic nw,
                       input logic [AW-1:0] fd, input logic fw);
    @(negedge clk);
    dec_src_a = sa; dec_src_b = sb;
    near_dst  = nd; near_wr   = nw;
    far_dst   = fd; far_wr    = fw;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(5'd3, 5'd3, 5'd3, 1'b1, 5'd3, 1'b1);
    check("R10 sel_a in reset", sel_a, 2'b00);
    check("R10 sel_b in reset", sel_b, 2'b00);
    rst = 1'b0;
  endtask

  task automatic t_none();
    apply(5'd1, 5'd2, 5'd7, 1'b1, 5'd9, 1'b1);
    check("R1 sel_a no match", sel_a, 2'b00);
    check("R1 sel_b no match", sel_b, 2'b00);
  endtask

  task automatic t_near();
    apply(5'd4, 5'd6, 5'd4, 1'b1, 5'd8, 1'b1);
    check("R2 sel_a near", sel_a, 2'b10);
    check("R2 sel_b untouched", sel_b, 2'b00);
  endtask

  task automatic t_far();
    apply(5'd12, 5'd13, 5'd20, 1'b1, 5'd13, 1'b1);
    check("R3 sel_a untouched", sel_a, 2'b00);
    check("R3 sel_b far", sel_b, 2'b01);
  endtask

  task automatic t_both();
    apply(5'd17, 5'd17, 5'd17, 1'b1, 5'd17, 1'b1);
    check("R4 sel_a both, near wins", sel_a, 2'b10);
    check("R4 sel_b both, near wins", sel_b, 2'b10);
  endtask

  task automatic t_zero();
    apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    check("R5 sel_a reg0", sel_a, 2'b00);
    check("R5 sel_b reg0", sel_b, 2'b00);
  endtask

  task automatic t_wr_off();
    apply(5'd9, 5'd9, 5'd9, 1'b0, 5'd9, 1'b1);
    check("R6 near off falls to far a", sel_a, 2'b01);
    check("R6 near off falls to far b", sel_b, 2'b01);
    apply(5'd9, 5'd10, 5'd9, 1'b0, 5'd10, 1'b0);
    check("R6 both off a", sel_a, 2'b00);
    check("R6 both off b", sel_b, 2'b00);
  endtask

  task automatic t_indep();
    apply(5'd21, 5'd22, 5'd22, 1'b1, 5'd21, 1'b1);
    check("R7 sel_a from far", sel_a, 2'b01);
    check("R7 sel_b from near", sel_b, 2'b10);
    apply(5'd31, 5'd30, 5'd31, 1'b1, 5'd30, 1'b1);
    check("R7 sel_a from near", sel_a, 2'b10);
    check("R7 sel_b from far", sel_b, 2'b01);
  endtask

  task automatic t_latency();
    apply(5'd1, 5'd1, 5'd2, 1'b1, 5'd2, 1'b1);
    check("R9 baseline", sel_a, 2'b00);
    @(negedge clk);
    dec_src_a = 5'd2;
    #1;
    check("R9 held before edge", sel_a, 2'b00);
    @(negedge clk);
    check("R9 updated after edge", sel_a, 2'b10);
    check("R8 legal code b", sel_b, 2'b00);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    t_reset();
    t_none();
    t_near();
    t_far();
    t_both();
    t_zero();
    t_wr_off();
    t_indep();
    t_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule